// File: doc/BRIEF.md
# Shadowed SRAM with Software Store and Recall

This block is a byte-wide static memory with a second, nonvolatile-style shadow array of the same size. On the host side it looks like a plain SRAM: address, write data, read data, and active-low chip, output and write enables. All of these are sampled on the rising edge of a system clock. In normal operation every enabled cycle is a single read or write to the working array.

A detector watches the enabled read accesses for a fixed chain of six addresses. The first five addresses are always the same. The sixth picks the operation:
- A STORE copies every word of the working array into the shadow.
- A RECALL first zeroes the working array and then loads it from the shadow.

A write, or a read at any other address, anywhere in the chain resets the detector and no transfer starts. A transfer moves one word per clock. While it runs, the block raises `busy_o`, ignores writes, does not count reads, and holds read data at zero. On release of reset the block starts a RECALL by itself, so the working array comes back from the shadow after every reset. The shadow array itself is never reset.

The default depth is 4096 words (`ADDR_W` = 12). Setting `ADDR_W` to 15 gives the full 32768 x 8 organisation.

Top module: `shadow_sram`

## Requirements
- R1: While `rst_ni` is low, `busy_o` is 1 and `rdata_o` is 0.
- R2: With `busy_o` low, a cycle with `ce_n_i`=0 and `we_n_i`=0 writes `wdata_i` to `addr_i`. A cycle with `ce_n_i`=0, `we_n_i`=1 and `oe_n_i`=0 places the addressed word on `rdata_o` after the next rising edge. If `oe_n_i`=1 in that cycle, `rdata_o` is 0 instead.
- R3: Six enabled reads at 0x0E38, 0x01C7, 0x03E0, 0x0C1F, 0x003F and then 0x0FC0 start a STORE. `busy_o` rises after the edge that samples the sixth read and stays high for exactly DEPTH cycles (DEPTH = 2^ADDR_W).
- R4: While `busy_o` is high, writes change nothing and `rdata_o` stays 0.
- R5: The same five addresses followed by 0x0C63 start a RECALL. Afterwards every word of the working array equals the shadow contents.
- R6: A RECALL is a clear sweep followed by a load sweep. `busy_o` stays high for exactly 2*DEPTH cycles.
- R7: An enabled write anywhere inside the chain aborts it, and no transfer starts.
- R8: An enabled read at an address that does not match the next step aborts the chain.
- R9: A RECALL leaves the shadow unchanged, so repeated RECALLs restore the same data.
- R10: Releasing reset starts a RECALL that lasts 2*DEPTH cycles. The shadow keeps its contents across reset.
- R11: Cycles with `ce_n_i`=1 are not accesses. They neither advance nor break the chain, whatever `we_n_i` is.
- R12: A sixth read at any address other than the two selectors starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| rdata_o | output | DATA_W | Registered read data, zero when not driven |
| busy_o | output | 1 | Transfer in progress |

## Verification
The hardest state to reach from the ports is a shadow whose contents differ from the working array, reached at the moment an abort, a second RECALL or a reset happens. Without that difference, a transfer that wrongly ran or wrongly failed to run could not be seen.

The bench therefore fills the whole array with one arithmetic pattern and stores it. It then overwrites the array, or selected words, with a second pattern. After each abort, repeated RECALL and reset, it reads the array back and checks that every word matches whichever pattern the requirements call for.

// File: rtl/shadow_sram_pkg.sv
package shadow_sram_pkg;
  typedef enum logic [1:0] {XF_IDLE, XF_STORE, XF_CLEAR, XF_LOAD} xfer_state_e;

  localparam int SEQ_PREFIX = 5;
  localparam logic [15:0] STORE_SEL  = 16'h0FC0;
  localparam logic [15:0] RECALL_SEL = 16'h0C63;

  function automatic logic [15:0] seq_addr(input logic [2:0] step);
    case (step)
      3'd0:    seq_addr = 16'h0E38;
      3'd1:    seq_addr = 16'h01C7;
      3'd2:    seq_addr = 16'h03E0;
      3'd3:    seq_addr = 16'h0C1F;
      3'd4:    seq_addr = 16'h003F;
      default: seq_addr = 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/shadow_seq_detect.sv
module shadow_seq_detect
  import shadow_sram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_acc_i,
  input  logic              wr_acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_store_o,
  output logic              start_recall_o
);
  logic [2:0]  step_q;
  logic [15:0] addr_ext;
  logic        at_final;
  logic        hit;

  assign addr_ext       = 16'(addr_i);
  assign at_final       = (step_q == 3'(SEQ_PREFIX));
  assign hit            = (addr_ext == seq_addr(step_q));
  assign start_store_o  = rd_acc_i && at_final && (addr_ext == STORE_SEL);
  assign start_recall_o = rd_acc_i && at_final && (addr_ext == RECALL_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     step_q <= '0;
    else if (wr_acc_i)               step_q <= '0;
    else if (rd_acc_i) begin
      if (!at_final && hit)          step_q <= step_q + 3'd1;
      else                           step_q <= '0;
    end
  end

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != $past(step_q)) |-> (step_q == '0 || step_q == $past(step_q) + 3'd1)); // R7
  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_store_o, start_recall_o})); // R3
  AST_START_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_store_o || start_recall_o) |=> (step_q == '0)); // R12
endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
  import shadow_sram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_store_i,
  input  logic              start_recall_i,
  output xfer_state_e       state_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              busy_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  xfer_state_e       state_q;
  logic [ADDR_W-1:0] idx_q;
  logic              last;

  assign last    = (idx_q == LAST_IDX);
  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign busy_o  = (state_q != XF_IDLE);

  // reset lands in the clear sweep: automatic recall on release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_CLEAR;
      idx_q   <= '0;
    end else begin
      case (state_q)
        XF_IDLE: begin
          idx_q <= '0;
          if (start_store_i)       state_q <= XF_STORE;
          else if (start_recall_i) state_q <= XF_CLEAR;
        end
        XF_STORE: begin
          idx_q <= idx_q + 1'b1;
          if (last) state_q <= XF_IDLE;
        end
        XF_CLEAR: begin
          idx_q <= idx_q + 1'b1;
          if (last) state_q <= XF_LOAD;
        end
        XF_LOAD: begin
          idx_q <= idx_q + 1'b1;
          if (last) state_q <= XF_IDLE;
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XF_IDLE && (start_store_i || start_recall_i)) |=> busy_o); // R3
  AST_CLEAR_TO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XF_CLEAR && last) |=> (state_q == XF_LOAD)); // R6
  AST_LOAD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XF_LOAD) |=> (state_q inside {XF_LOAD, XF_IDLE})); // R6
endmodule

// File: rtl/shadow_arrays.sv
module shadow_arrays
  import shadow_sram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  xfer_state_e       state_i,
  input  logic [ADDR_W-1:0] idx_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_mem   [DEPTH];
  logic [DATA_W-1:0] shadow_mem [DEPTH];

  assign host_rdata_o = work_mem[host_addr_i];

  always_ff @(posedge clk_i) begin
    case (state_i)
      XF_CLEAR: work_mem[idx_i] <= '0;
      XF_LOAD:  work_mem[idx_i] <= shadow_mem[idx_i];
      XF_IDLE:  if (host_we_i) work_mem[host_addr_i] <= host_wdata_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (state_i == XF_STORE) shadow_mem[idx_i] <= work_mem[idx_i];
  end
endmodule

// File: rtl/shadow_sram.sv
module shadow_sram
  import shadow_sram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  logic              busy;
  logic              rd_acc, wr_acc;
  logic              start_store, start_recall;
  xfer_state_e       state;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] arr_rdata;

  assign rd_acc = !ce_n_i &&  we_n_i && !busy;
  assign wr_acc = !ce_n_i && !we_n_i && !busy;
  assign busy_o = busy;

  shadow_seq_detect #(.ADDR_W(ADDR_W)) u_detect (
    .clk_i, .rst_ni,
    .rd_acc_i      (rd_acc),
    .wr_acc_i      (wr_acc),
    .addr_i        (addr_i),
    .start_store_o (start_store),
    .start_recall_o(start_recall)
  );

  shadow_xfer_ctrl #(.ADDR_W(ADDR_W)) u_xfer (
    .clk_i, .rst_ni,
    .start_store_i (start_store),
    .start_recall_i(start_recall),
    .state_o       (state),
    .idx_o         (idx),
    .busy_o        (busy)
  );

  shadow_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arrays (
    .clk_i,
    .host_we_i   (wr_acc),
    .host_addr_i (addr_i),
    .host_wdata_i(wdata_i),
    .host_rdata_o(arr_rdata),
    .state_i     (state),
    .idx_i       (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (rd_acc && !oe_n_i) rdata_o <= arr_rdata;
    else                        rdata_o <= '0;
  end

  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (rdata_o == '0)); // R4
endmodule

// File: tb/tb_shadow_sram.sv
`timescale 1ns/1ps
module tb_shadow_sram;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              ce_n = 1, oe_n = 1, we_n = 1;
  logic [DATA_W-1:0] rdata;
  logic              busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  shadow_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .rdata_o(rdata), .busy_o(busy)
  );

  function automatic logic [7:0] pat_a(int a);
    return 8'(a * 37 + (a >> 5) + 11);
  endfunction
  function automatic logic [7:0] pat_b(int a);
    return 8'(~(a * 13)) ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic rd(int a, bit use_oe, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); ce_n = 0; we_n = 1; oe_n = !use_oe;
    @(negedge clk);
    d = rdata;
    go_idle();
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    go_idle();
  endtask

  task automatic prefix(int upto);
    logic [7:0] d;
    int seqv[5] = '{'h0E38, 'h01C7, 'h03E0, 'h0C1F, 'h003F};
    for (int i = 0; i < upto && i < 5; i++) rd(seqv[i], 1, d);
  endtask

  task automatic suffix(int from);
    logic [7:0] d;
    int seqv[5] = '{'h0E38, 'h01C7, 'h03E0, 'h0C1F, 'h003F};
    for (int i = from; i < 5; i++) rd(seqv[i], 1, d);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 3 * DEPTH) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fill(bit use_a);
    for (int a = 0; a < DEPTH; a++) wr(a, use_a ? pat_a(a) : pat_b(a));
  endtask

  task automatic verify_a(string req);
    logic [7:0] d;
    int bad = 0;
    int first = -1;
    logic [7:0] fv = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, 1, d);
      if (d !== pat_a(a)) begin
        bad++;
        if (first < 0) begin
          first = a;
          fv = d;
        end
      end
    end
    check(bad == 0, req, fv, (first < 0) ? 0 : int'(pat_a(first)));
  endtask

  initial begin
    #(200000 * 10);
    $display("FAIL watchdog expired");
    n_tests++;
    n_fail++;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R1 busy in reset", busy, 1);
    check(rdata === '0, "R1 rdata in reset", rdata, 0);
    rst_n = 1;
    busy_len(n);
    check(n == 2 * DEPTH, "R10 power-up recall length", n, 2 * DEPTH);

    // R2 full sweep, output enable gating
    fill(1);
    verify_a("R2 read back");
    rd(77, 0, d);
    check(d === '0, "R2 oe inactive", d, 0);

    // R3 store
    prefix(5);
    rd('h0FC0, 1, d);
    check(busy === 1'b1, "R3 busy after store", busy, 1);
    busy_len(n);
    check(n == DEPTH, "R3 store length", n, DEPTH);

    // R4 lockout during busy
    prefix(5);
    rd('h0FC0, 1, d);
    for (int i = 0; i < 10; i++) begin
      wr(5, 8'hAA);
      rd(5, 1, d);
      check(d === '0, "R4 rdata while busy", d, 0);
    end
    while (busy) @(negedge clk);
    rd(5, 1, d);
    check(d === pat_a(5), "R4 write ignored", d, pat_a(5));

    // R5/R6 recall
    fill(0);
    prefix(5);
    rd('h0C63, 1, d);
    busy_len(n);
    check(n == 2 * DEPTH, "R6 recall length", n, 2 * DEPTH);
    verify_a("R5 recall restores");

    // R9 repeated recall
    for (int a = 0; a < DEPTH; a += 7) wr(a, pat_b(a));
    prefix(5);
    rd('h0C63, 1, d);
    while (busy) @(negedge clk);
    verify_a("R9 second recall");

    // R7 write aborts
    wr(100, 8'h77);
    prefix(3);
    wr(200, pat_a(200));
    suffix(3);
    rd('h0C63, 1, d);
    check(busy === 1'b0, "R7 no busy", busy, 0);
    rd(100, 1, d);
    check(d === 8'h77, "R7 data kept", d, 8'h77);

    // R8 wrong read aborts
    prefix(2);
    rd('h0123, 1, d);
    suffix(2);
    rd('h0C63, 1, d);
    check(busy === 1'b0, "R8 no busy", busy, 0);
    rd(100, 1, d);
    check(d === 8'h77, "R8 data kept", d, 8'h77);

    // R12 wrong selector
    prefix(5);
    rd('h0ABC, 1, d);
    check(busy === 1'b0, "R12 no busy", busy, 0);
    rd(100, 1, d);
    check(d === 8'h77, "R12 data kept", d, 8'h77);

    // R11 deselected cycles inside the chain, including one with write low
    prefix(3);
    @(negedge clk);
    addr = ADDR_W'(300); ce_n = 1; we_n = 0;
    @(negedge clk);
    go_idle();
    repeat (3) @(negedge clk);
    suffix(3);
    rd('h0C63, 1, d);
    check(busy === 1'b1, "R11 chain survives", busy, 1);
    while (busy) @(negedge clk);
    rd(100, 1, d);
    check(d === pat_a(100), "R11 recall ran", d, pat_a(100));

    // R10 reset recall from persisting shadow
    wr(100, 8'h77);
    wr(4095, 8'h00);
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    busy_len(n);
    check(n == 2 * DEPTH, "R10 reset recall length", n, 2 * DEPTH);
    verify_a("R10 shadow kept across reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule